// File: doc/BRIEF.md
# Line Write Buffer and Program-Cycle Controller

This block sits behind the serial-bus front end of a small non-volatile byte store. The front end decodes the bus and hands over events: a matched write-select, each received byte, each request for a read byte, and STOP (with a flag that says whether STOP fell right after an acknowledge slot). The block takes the first byte after a write-select as the byte address. Following data bytes go into a 16-entry line buffer, acknowledged or refused one by one. When STOP lands on a byte boundary and the buffer holds at least one accepted byte, the block runs a timed program cycle and then copies the buffer into a behavioural array.

The full array address is the page-select bit followed by the 8-bit byte address. The array is split into four lock blocks indexed by the two top bits of that address. While the program cycle runs, `busy` is high and every incoming event is dropped. Reads return one byte per request from a shared address pointer, so random, current-address and sequential reads all use the same mechanism.

States: `S_IDLE` (no transaction), `S_ADDR` (waiting for the address byte), `S_DATA` (collecting data bytes), `S_PROG` (program cycle). The transitions are as follows. A write-select moves any non-busy state to `S_ADDR`. The address byte moves `S_ADDR` to `S_DATA`. A boundary STOP with buffered data moves `S_DATA` to `S_PROG`. Any other STOP, and any read request, returns to `S_IDLE`. Expiry of the timer moves `S_PROG` to `S_IDLE`. STOP takes priority over write-select, write-select over read request, and read request over a byte.

Top module: `linewr_ctrl`

## Requirements
- R1: In `S_ADDR` a received byte is always acknowledged (`ack_vld`=1, `ack`=1 one cycle later), becomes the pointer, and latches `page_sel` for the write.
- R2: Each data byte (acknowledged or not) advances only the low four pointer bits, so the 17th byte of a burst replaces the first slot of the same 16-byte line; only the last byte written to a slot is programmed.
- R3: A data byte whose block `{page, addr[7]}` has its `blk_lock` bit set (bit index = that 2-bit value) is refused (`ack`=0) and its location keeps its old content.
- R4: While `wr_ctl` is 1 every data byte is refused (`ack`=0) and nothing is programmed; the address byte is still acknowledged.
- R5: A STOP with `stop_aligned`=1 in `S_DATA`, with at least one accepted byte buffered, raises `busy` for exactly `WCYC` cycles, after which the accepted bytes are in the array.
- R6: A STOP with `stop_aligned`=0, a STOP before any accepted data byte, or a new write-select during `S_DATA` leaves `busy` low and the array unchanged.
- R7: While `busy` is 1, bytes and read requests produce no `ack_vld` and no `rd_vld`.
- R8: Data written with `page_sel`=1 is stored and read only at `{1, addr}`; the same byte address with `page_sel`=0 is a different location.
- R9: Each read request returns, one cycle later with `rd_vld`=1, the byte at `{page_sel, ptr}` and increments the full 8-bit pointer, wrapping from 0xFF to 0x00 in the same page.
- R10: A read request with no new address continues at the location after the last byte read or written.
- R11: After reset `busy`, `ack_vld` and `rd_vld` are 0 and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_wr | input | 1 | Pulse: matched select byte with write direction |
| byte_vld | input | 1 | Pulse: a byte from the master is on `byte_in` |
| byte_in | input | 8 | Received byte |
| rd_req | input | 1 | Pulse: master wants the next read byte |
| stop_evt | input | 1 | Pulse: STOP seen on the bus |
| stop_aligned | input | 1 | STOP fell right after an acknowledge slot |
| page_sel | input | 1 | Current page bit |
| blk_lock | input | 4 | Per-block write lock, index `{page, addr[7]}` |
| wr_ctl | input | 1 | Write-control pin, 1 refuses all writes |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_vld | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Program cycle in progress |

## Verification
The hardest situation to reach is an event that arrives in the middle of a program cycle. It only exists for the `WCYC` cycles after a correctly placed STOP. The bench counts busy cycles as they pass, injects a byte and a read request together at a fixed offset into the cycle, and checks that neither produces a response. Line wrap is reached by sending an 18-byte burst that starts two bytes before the end of a line. The result is then read back sequentially, so the overwritten slots show up at the ports.

// File: rtl/linewr_pkg.sv
package linewr_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_DATA,
        S_PROG
    } lw_state_e;
endpackage

// File: rtl/linewr_buf.sv
// Line buffer: one data register and one valid bit per slot.
module linewr_buf #(
    parameter int LINE_W = 4,
    parameter int DATA_W = 8,
    localparam int LINE_N = 1 << LINE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           wr_en,
    input  logic [LINE_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [LINE_N-1:0][DATA_W-1:0]  data,
    output logic [LINE_N-1:0]              mask
);
    for (genvar g = 0; g < LINE_N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[g] <= 1'b0;
            end else if (clr) begin
                mask[g] <= 1'b0;
            end else if (wr_en && wr_idx == LINE_W'(g)) begin
                mask[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == LINE_W'(g)) begin
                data[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/linewr_timer.sv
// Program-cycle timer: loaded on entry, done on its last cycle.
module linewr_timer #(
    parameter int WCYC = 40,
    localparam int CNT_W = $clog2(WCYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(WCYC - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/linewr_array.sv
// Behavioural storage array with a line-wide commit port.
module linewr_array #(
    parameter int FULL_W = 9,
    parameter int LINE_W = 4,
    parameter int DATA_W = 8,
    localparam int LINE_N = 1 << LINE_W,
    localparam int TAG_W  = FULL_W - LINE_W,
    localparam int DEPTH  = 1 << FULL_W
) (
    input  logic                           clk,
    input  logic                           commit,
    input  logic [TAG_W-1:0]               tag,
    input  logic [LINE_N-1:0][DATA_W-1:0]  data,
    input  logic [LINE_N-1:0]              mask,
    input  logic [FULL_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_byte
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < LINE_N; i++) begin
                if (mask[i]) begin
                    mem[{tag, LINE_W'(i)}] <= data[i];
                end
            end
        end
    end

    assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/linewr_ctrl.sv
module linewr_ctrl
    import linewr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINE_W = 4,
    parameter int DATA_W = 8,
    parameter int BLK_W  = 2,
    parameter int WCYC   = 40,
    localparam int FULL_W = ADDR_W + 1,
    localparam int LINE_N = 1 << LINE_W,
    localparam int TAG_W  = FULL_W - LINE_W,
    localparam int BLK_N  = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic              byte_vld,
    input  logic [ADDR_W-1:0] byte_in,
    input  logic              rd_req,
    input  logic              stop_evt,
    input  logic              stop_aligned,
    input  logic              page_sel,
    input  logic [BLK_N-1:0]  blk_lock,
    input  logic              wr_ctl,
    output logic              ack_vld,
    output logic              ack,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    lw_state_e state, state_nx;

    logic [ADDR_W-1:0]               ptr;
    logic                            wr_page;
    logic [FULL_W-1:0]               wr_full;
    logic [BLK_W-1:0]                blk_idx;
    logic                            lock_hit;
    logic                            accept;
    logic                            live;
    logic                            ev_addr, ev_data, ev_read, ev_sel;
    logic                            stop_commit;
    logic                            tmr_done;
    logic                            commit;
    logic [LINE_N-1:0][DATA_W-1:0]   buf_data;
    logic [LINE_N-1:0]               buf_mask;
    logic [DATA_W-1:0]               mem_byte;

    // Event decode with priority STOP > select > read > byte
    assign live    = (state != S_PROG);
    assign ev_sel  = live && !stop_evt && sel_wr;
    assign ev_read = live && !stop_evt && !sel_wr && rd_req;
    assign ev_addr = live && !stop_evt && !sel_wr && !rd_req && byte_vld && state == S_ADDR;
    assign ev_data = live && !stop_evt && !sel_wr && !rd_req && byte_vld && state == S_DATA;

    assign wr_full     = {wr_page, ptr};
    assign blk_idx     = wr_full[FULL_W-1 -: BLK_W];
    assign lock_hit    = blk_lock[blk_idx];
    assign accept      = !wr_ctl && !lock_hit;
    assign stop_commit = (state == S_DATA) && stop_evt && stop_aligned && (|buf_mask);
    assign commit      = (state == S_PROG) && tmr_done;
    assign busy        = (state == S_PROG);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_PROG: begin
                if (tmr_done) state_nx = S_IDLE;
            end
            S_IDLE, S_ADDR, S_DATA: begin
                if (stop_evt)      state_nx = stop_commit ? S_PROG : S_IDLE;
                else if (ev_sel)   state_nx = S_ADDR;
                else if (ev_read)  state_nx = S_IDLE;
                else if (ev_addr)  state_nx = S_DATA;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Address pointer and write page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            wr_page <= 1'b0;
        end else if (ev_addr) begin
            ptr     <= byte_in;
            wr_page <= page_sel;
        end else if (ev_data) begin
            ptr[LINE_W-1:0] <= ptr[LINE_W-1:0] + 1'b1;
        end else if (ev_read) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack     <= 1'b0;
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            ack_vld <= ev_addr || ev_data;
            ack     <= ev_addr || (ev_data && accept);
            rd_vld  <= ev_read;
            if (ev_read) rd_data <= mem_byte;
        end
    end

    linewr_buf #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ev_addr),
        .wr_en   (ev_data && accept),
        .wr_idx  (ptr[LINE_W-1:0]),
        .wr_data (byte_in),
        .data    (buf_data),
        .mask    (buf_mask)
    );

    linewr_timer #(.WCYC(WCYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stop_commit),
        .run   (busy),
        .done  (tmr_done)
    );

    linewr_array #(.FULL_W(FULL_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .commit  (commit),
        .tag     (wr_full[FULL_W-1:LINE_W]),
        .data    (buf_data),
        .mask    (buf_mask),
        .rd_addr ({page_sel, ptr}),
        .rd_byte (mem_byte)
    );
endmodule

// File: rtl/linewr_chk.sv
module linewr_chk #(
    parameter int WCYC = 40,
    localparam int RUN_W = $clog2(WCYC + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic byte_vld,
    input logic sel_wr,
    input logic rd_req,
    input logic stop_evt,
    input logic stop_aligned,
    input logic wr_ctl,
    input logic in_addr,
    input logic in_data,
    input logic lock_hit,
    input logic ack_vld,
    input logic ack,
    input logic rd_vld,
    input logic busy
);
    logic [RUN_W-1:0] run;
    logic             plain_byte;

    assign plain_byte = byte_vld && !stop_evt && !sel_wr && !rd_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    a_r1_addr_acked: assert property (@(posedge clk) disable iff (!rst_n)
        plain_byte && in_addr |=> ack_vld && ack);

    a_r3_locked_refused: assert property (@(posedge clk) disable iff (!rst_n)
        plain_byte && in_data && lock_hit |=> ack_vld && !ack);

    a_r4_wrctl_refused: assert property (@(posedge clk) disable iff (!rst_n)
        plain_byte && in_data && wr_ctl |=> ack_vld && !ack);

    a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run < RUN_W'(WCYC));

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run == RUN_W'(WCYC));

    a_r6_busy_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt && stop_aligned && in_data));

    a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_vld && !rd_vld);
endmodule

bind linewr_ctrl linewr_chk #(.WCYC(WCYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .sel_wr       (sel_wr),
    .rd_req       (rd_req),
    .stop_evt     (stop_evt),
    .stop_aligned (stop_aligned),
    .wr_ctl       (wr_ctl),
    .in_addr      (state == S_ADDR),
    .in_data      (state == S_DATA),
    .lock_hit     (lock_hit),
    .ack_vld      (ack_vld),
    .ack          (ack),
    .rd_vld       (rd_vld),
    .busy         (busy)
);

// File: tb/test_linewr_ctrl.sv
module test_linewr_ctrl;
    localparam int WCYC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 0, byte_vld = 0, rd_req = 0, stop_evt = 0, stop_aligned = 0;
    logic [7:0] byte_in = 0;
    logic       page_sel = 0, wr_ctl = 0;
    logic [3:0] blk_lock = 0;
    logic       ack_vld, ack, rd_vld, busy;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] mem_m [512];
    logic [7:0] cur_ptr = 0;

    always #2 clk = ~clk;

    linewr_ctrl #(.WCYC(WCYC)) i_linewr_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .byte_vld(byte_vld), .byte_in(byte_in),
        .rd_req(rd_req), .stop_evt(stop_evt), .stop_aligned(stop_aligned), .page_sel(page_sel),
        .blk_lock(blk_lock), .wr_ctl(wr_ctl), .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld),
        .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_ptr = 8'h00;
        @(negedge clk);
    endtask

    task automatic pulse_sel(input logic pg);
        @(negedge clk) sel_wr = 1; page_sel = pg;
        @(negedge clk) sel_wr = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic got_vld, output logic got_ack);
        @(negedge clk) byte_vld = 1; byte_in = b;
        @(negedge clk) byte_vld = 0;
        got_vld = ack_vld; got_ack = ack;
    endtask

    // Count busy cycles; optionally poke the bus in the middle of them (R7)
    task automatic wait_busy(input bit poke, output int n);
        n = 0;
        while (busy && n < 10 * WCYC) begin
            n++;
            if (poke && n == 2) begin rd_req = 1; byte_vld = 1; byte_in = 8'hEE; end
            if (poke && n == 3) begin
                rd_req = 0; byte_vld = 0;
                check("R7 ack_vld during busy", ack_vld, 0);
                check("R7 rd_vld during busy", rd_vld, 0);
            end
            @(negedge clk);
        end
        rd_req = 0; byte_vld = 0;
    endtask

    task automatic do_stop(input logic aligned, input bit expect_prog, input bit poke, input string req);
        int n;
        @(negedge clk) stop_evt = 1; stop_aligned = aligned;
        @(negedge clk) stop_evt = 0; stop_aligned = 0;
        wait_busy(poke, n);
        check(req, n, expect_prog ? WCYC : 0);
    endtask

    // Write transaction: n bytes base, base+1, ...; model follows the requirements
    task automatic wr_txn(input logic pg, input logic [7:0] a, input int n, input logic [7:0] base,
                          input logic aligned, input bit poke, input string req);
        logic [7:0] lb [16];
        bit         lm [16];
        logic [7:0] p;
        logic       v, k, exp;
        bit         any;
        any = 0;
        for (int i = 0; i < 16; i++) lm[i] = 0;
        p = a;
        pulse_sel(pg);
        send_byte(a, v, k);
        check("R1 address byte ack", {v, k}, 2'b11);
        for (int i = 0; i < n; i++) begin
            exp = !wr_ctl && !blk_lock[{pg, p[7]}];
            send_byte(base + 8'(i), v, k);
            check({req, " data ack"}, {v, k}, {1'b1, exp});
            if (exp) begin lb[p[3:0]] = base + 8'(i); lm[p[3:0]] = 1; any = 1; end
            p[3:0] = p[3:0] + 1;
        end
        do_stop(aligned, aligned && any, poke, {req, " busy length"});
        if (aligned && any)
            for (int j = 0; j < 16; j++)
                if (lm[j]) mem_m[{pg, a[7:4], 4'(j)}] = lb[j];
        cur_ptr = p;
    endtask

    task automatic rd_one(input logic pg, input string req);
        @(negedge clk) rd_req = 1; page_sel = pg;
        @(negedge clk) rd_req = 0;
        check({req, " rd_vld"}, rd_vld, 1);
        check({req, " rd_data"}, rd_data, mem_m[{pg, cur_ptr}]);
        cur_ptr = cur_ptr + 1;
    endtask

    task automatic rd_txn(input logic pg, input logic [7:0] a, input int n, input string req);
        logic v, k;
        pulse_sel(pg);
        send_byte(a, v, k);
        cur_ptr = a;
        for (int i = 0; i < n; i++) rd_one(pg, req);
    endtask

    task automatic t_reset();
        check("R11 busy after reset", busy, 0);
        check("R11 ack_vld after reset", ack_vld, 0);
        check("R11 rd_vld after reset", rd_vld, 0);
    endtask

    task automatic t_byte_write();
        wr_txn(0, 8'h00, 1, 8'h5A, 1, 1, "R5 byte write");
        rd_txn(0, 8'h00, 1, "R1 random read");
    endtask

    task automatic t_line_wrap();
        wr_txn(0, 8'h2E, 18, 8'h10, 1, 0, "R2 line wrap");
        rd_txn(0, 8'h20, 16, "R2 R9 line readback");
    endtask

    task automatic t_page();
        wr_txn(1, 8'h2E, 1, 8'hA5, 1, 0, "R8 page1 write");
        rd_txn(1, 8'h2E, 1, "R8 page1 read");
        rd_txn(0, 8'h2E, 1, "R8 page0 untouched");
    endtask

    task automatic t_lock();
        wr_txn(0, 8'h80, 1, 8'h33, 1, 0, "R3 prefill");
        blk_lock = 4'b0010;
        wr_txn(0, 8'h80, 1, 8'hC3, 1, 0, "R3 locked");
        wr_txn(0, 8'h05, 1, 8'h44, 1, 0, "R3 unlocked block");
        blk_lock = 4'b0000;
        rd_txn(0, 8'h80, 1, "R3 locked content kept");
        rd_txn(0, 8'h05, 1, "R3 other block written");
    endtask

    task automatic t_wrctl();
        wr_ctl = 1;
        wr_txn(0, 8'h00, 2, 8'h99, 1, 0, "R4 wr_ctl high");
        wr_ctl = 0;
        rd_txn(0, 8'h00, 1, "R4 content kept");
    endtask

    task automatic t_abort();
        logic v, k;
        wr_txn(0, 8'h00, 1, 8'h77, 0, 0, "R6 misaligned stop");
        rd_txn(0, 8'h00, 1, "R6 after misaligned");
        pulse_sel(0);
        send_byte(8'h00, v, k);
        do_stop(1, 0, 0, "R6 stop after address only");
        pulse_sel(0);
        send_byte(8'h00, v, k);
        send_byte(8'h66, v, k);
        pulse_sel(0);
        do_stop(1, 0, 0, "R6 restart discards buffer");
        rd_txn(0, 8'h00, 1, "R6 content after restart");
    endtask

    task automatic t_seq_wrap();
        wr_txn(0, 8'hFF, 1, 8'hF1, 1, 0, "R9 fill FF");
        wr_txn(0, 8'h00, 1, 8'h01, 1, 0, "R9 fill 00");
        rd_txn(0, 8'hFF, 2, "R9 wrap FF to 00");
    endtask

    task automatic t_current();
        wr_txn(0, 8'h2D, 1, 8'hB7, 1, 0, "R10 write");
        rd_one(0, "R10 current after write");
        rd_one(0, "R10 current continues");
    endtask

    task automatic t_reset_ptr();
        do_reset();
        rd_one(0, "R11 pointer zero");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_byte_write();
        t_line_wrap();
        t_page();
        t_lock();
        t_wrctl();
        t_abort();
        t_seq_wrap();
        t_current();
        t_reset_ptr();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule